// File: doc/BRIEF.md
# Program Counter and Next-Address Unit

This block keeps the address of the instruction being executed and decides, once per clock, where execution goes next. It drives that address to an instruction memory, which answers combinationally, and passes the returned word on to the decoder. In the same cycle, the datapath supplies a flag that marks the current instruction as a conditional branch. It also supplies a flag that reports whether the two compared registers hold equal values. The unit also receives the 16-bit immediate field of the instruction.

At each rising clock edge the counter loads one of two values. It loads the sequential address, PC+4, unless both flags are high. In that case it loads the branch target. The target is formed by sign-extending the immediate, scaling it from words to bytes, and adding the result to PC+4. Because the redirect happens on the edge that ends the branch's own cycle, the instruction after a taken branch is fetched from the target directly. A synchronous reset returns the counter to a fixed start address.

Top module: `fetch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the PC loads 0x00000000 on that edge, whatever the branch inputs are.
- R2: With `br_inst` low and `br_eq` low, each rising edge sets PC to PC+4.
- R3: When `br_inst` and `br_eq` are both high at a rising edge, PC becomes PC+4 plus the sign-extended `br_imm` shifted left by two bits. For example, an immediate of 12 moves the PC forward by 52 bytes.
- R4: If only one of `br_inst` and `br_eq` is high, the branch is not taken. The next PC is PC+4 and `br_imm` has no effect.
- R5: Immediates with bit 15 set are negative word offsets. For example, 0xFFFF gives a target equal to the branch's own address, and 0x8000 gives PC+4-131072.
- R6: All address arithmetic wraps modulo 2^32. For example, a taken branch at PC 0 with immediate 0xFFFE lands at 0xFFFFFFFC, and the next sequential step returns the PC to 0.
- R7: `imem_addr` always equals the current PC. In the same cycle, `instr` equals `imem_rdata`, with no register in between.
- R8: PC bits 1:0 are zero at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| br_inst | input | 1 | Current instruction is a conditional branch |
| br_eq | input | 1 | Compared registers are equal |
| br_imm | input | 16 | Signed word offset from the instruction |
| imem_addr | output | 32 | Address to the instruction memory (the PC) |
| imem_rdata | input | 32 | Word returned by the instruction memory |
| instr | output | 32 | Fetched instruction word to the decoder |

## Verification
The PC result of a set of branch inputs appears exactly one rising edge after those inputs are applied. The fetched word follows the new address in the same cycle, with no further delay. The bench applies inputs on the falling edge and computes the expected PC from the value it read at that falling edge. It then compares the PC and the fetched word at the next falling edge, so each check samples the cycle after its stimulus. The bench sweeps every one of the 65536 immediates as taken branches, which covers the backward offsets and the wrap past zero. Short sequences cover the untaken flag combinations and reset in the middle of a run.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef enum logic {
    NXT_SEQ = 1'b0,
    NXT_BR  = 1'b1
  } nxt_sel_e;

  localparam int unsigned INSTR_BYTES = 4;

endpackage

// File: rtl/fetch_next_pc.sv
module fetch_next_pc
  import fetch_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [AW-1:0]    cur_pc,
  input  logic             take,
  input  logic [IMM_W-1:0] imm,
  output logic [AW-1:0]    nxt_pc
);

  localparam int unsigned SHIFT = $clog2(INSTR_BYTES);
  localparam int unsigned EXT_W = AW - IMM_W - SHIFT;

  logic [AW-1:0] seq_addr;
  logic [AW-1:0] byte_off;
  logic [AW-1:0] tgt_addr;
  nxt_sel_e      sel;

  // Sign-extend the word offset and scale it to bytes.
  generate
    if (EXT_W > 0) begin : g_ext
      assign byte_off = {{EXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};
    end else begin : g_trunc
      assign byte_off = AW'({imm, {SHIFT{1'b0}}});
    end
  endgenerate

  assign seq_addr = cur_pc + AW'(INSTR_BYTES);
  assign tgt_addr = seq_addr + byte_off;
  assign sel      = take ? NXT_BR : NXT_SEQ;

  always_comb begin
    unique case (sel)
      NXT_BR:  nxt_pc = tgt_addr;
      default: nxt_pc = seq_addr;
    endcase
  end

endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg #(
  parameter int unsigned    AW         = 32,
  parameter logic [AW-1:0]  RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] nxt_pc,
  output logic [AW-1:0] pc
);

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_ADDR;
    else     pc <= nxt_pc;
  end

  // R1
  reset_load_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pc == RESET_ADDR);

endmodule

// File: rtl/fetch_unit.sv
module fetch_unit #(
  parameter int unsigned   AW         = 32,
  parameter int unsigned   IMM_W      = 16,
  parameter int unsigned   DW         = 32,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             br_inst,
  input  logic             br_eq,
  input  logic [IMM_W-1:0] br_imm,
  output logic [AW-1:0]    imem_addr,
  input  logic [DW-1:0]    imem_rdata,
  output logic [DW-1:0]    instr
);

  localparam int unsigned EXT_W = AW - IMM_W - 2;

  logic          take;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_d;

  assign take = br_inst & br_eq;

  fetch_next_pc #(.AW(AW), .IMM_W(IMM_W)) u_next (
    .cur_pc (pc_q),
    .take   (take),
    .imm    (br_imm),
    .nxt_pc (pc_d)
  );

  fetch_pc_reg #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_pc (
    .clk    (clk),
    .rst    (rst),
    .nxt_pc (pc_d),
    .pc     (pc_q)
  );

  assign imem_addr = pc_q;
  assign instr     = imem_rdata;

  // R2 R4
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    !(br_inst && br_eq) |=> imem_addr == $past(imem_addr) + AW'(4));

  // R3 R5 R6
  taken_step_chk: assert property (@(posedge clk) disable iff (rst)
    (br_inst && br_eq) |=> imem_addr == $past(imem_addr) + AW'(4)
      + {{EXT_W{$past(br_imm[IMM_W-1])}}, $past(br_imm), 2'b00});

  // R8
  aligned_chk: assert property (@(posedge clk) disable iff (rst)
    imem_addr[1:0] == 2'b00);

endmodule

// File: tb/fetch_unit_tb.sv
module fetch_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br_inst = 1'b0;
  logic        br_eq = 1'b0;
  logic [15:0] br_imm = '0;
  logic [31:0] imem_addr;
  logic [31:0] imem_rdata;
  logic [31:0] instr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // Model memory: word depends on the address.
  assign imem_rdata = {imem_addr[15:0] ^ 16'h5A3C, ~imem_addr[31:16]};

  fetch_unit u_dut (
    .clk        (clk),
    .rst        (rst),
    .br_inst    (br_inst),
    .br_eq      (br_eq),
    .br_imm     (br_imm),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .instr      (instr)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[31:16]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Apply inputs at negedge, check PC and word one edge later.
  task automatic step(input string req, input logic bi, input logic be,
                      input logic [15:0] imm);
    logic [31:0] cur;
    logic [31:0] exp;
    cur = imem_addr;
    br_inst = bi;
    br_eq = be;
    br_imm = imm;
    exp = cur + 32'd4;
    if (bi && be) exp = exp + {{14{imm[15]}}, imm, 2'b00};
    @(negedge clk);
    check(req, imem_addr, exp);
    check({req, "/R7"}, instr, mem_word(exp));
    check({req, "/R8"}, {30'd0, imem_addr[1:0]}, 32'd0);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    br_inst = 1'b1; br_eq = 1'b1; br_imm = 16'h1234;
    @(negedge clk); @(negedge clk);
    // R1 reset dominates branch inputs
    check("R1", imem_addr, 32'h0);
    check("R1/R7", instr, mem_word(32'h0));
    rst = 1'b0;
    // R2 sequential
    for (int i = 0; i < 5; i++) step("R2", 1'b0, 1'b0, 16'hFFFF);
    // R4 only one flag high
    step("R4", 1'b1, 1'b0, 16'h0100);
    step("R4", 1'b0, 1'b1, 16'h8000);
    // R3 immediate 12 -> +52
    begin
      logic [31:0] b;
      b = imem_addr;
      step("R3", 1'b1, 1'b1, 16'd12);
      check("R3", imem_addr, b + 32'd52);
      // R5 0xFFFF returns to own address
      b = imem_addr;
      step("R5", 1'b1, 1'b1, 16'hFFFF);
      check("R5", imem_addr, b);
      step("R5", 1'b1, 1'b1, 16'h8000);
    end
    // R1 mid-run reset, then R6 wrap below zero
    rst = 1'b1;
    @(negedge clk);
    check("R1", imem_addr, 32'h0);
    rst = 1'b0;
    step("R6", 1'b1, 1'b1, 16'hFFFE);
    check("R6", imem_addr, 32'hFFFF_FFFC);
    step("R6", 1'b0, 1'b0, 16'h0);
    check("R6", imem_addr, 32'h0);
    // R3 R5 R6 sweep every immediate as a taken branch
    for (int k = 0; k < 65536; k++) step("R3", 1'b1, 1'b1, 16'(k));
    for (int k = 0; k < 4; k++) step("R2", 1'b0, 1'b0, 16'(k));
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule